// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller connects a clocked host to an external 128K x 8 asynchronous static RAM. The host raises a request with a read/write flag, an address and, for writes, a data byte. The controller then drives the memory pins through a fixed, cycle-counted sequence and reports completion with a one-cycle strobe. For reads, that strobe comes with the captured byte.

The memory has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. Its 8-bit data bus is bidirectional, and the controller reaches it through separate out, out-enable and in signals. Every interval is a whole number of clock cycles, computed as ceil(ns / CLK_NS) with a floor of one cycle, from the nanosecond minimums of the selected speed grade. The fast grade uses these minimums:

| Interval | Fast grade |
|---|---|
| access / cycle | 30 ns |
| output-enable access | 12 ns |
| write pulse | 22 ns |
| data setup | 18 ns |
| float after write strobe falls | 8 ns |
| float after deselect | 18 ns |

The slow grade uses 45, 15, 35, 25, 15 and 20 ns for the same intervals. The write is ended by the write strobe, and bus drivers are sequenced so the controller never drives while the memory outputs may still be active.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever idle: req_ready_o=1, mem_cs1_n_o=1, mem_cs2_o=0, mem_we_n_o=1, mem_oe_n_o=1, mem_dq_oe_o=0, rsp_done_o=0; with req_valid_i low the chip stays deselected.
- R2: A request is taken only on a clock edge where req_valid_i and req_ready_o are both 1; req_ready_o is 0 from the next cycle until the access has fully finished.
- R3: A read holds mem_cs1_n_o=0, mem_cs2_o=1, mem_we_n_o=1 and mem_oe_n_o=0 for exactly N_RD = max(ceil(t_acc/CLK_NS), ceil(t_oe/CLK_NS)) consecutive cycles, starting in the cycle after acceptance.
- R4: rsp_rdata_o takes the mem_dq_i value present in the last output-enable-low cycle, and rsp_done_o is 1 for exactly the one cycle after it.
- R5: After a read, the chip is deselected with mem_oe_n_o=1 for N_RR = ceil(t_csz/CLK_NS) cycles, and req_ready_o returns in the cycle after that.
- R6: A write starts in the cycle after acceptance with the chip selected, mem_we_n_o=0 and mem_dq_oe_o=0 for N_WZ = ceil(t_wz/CLK_NS) cycles.
- R7: mem_dq_oe_o=1 while mem_we_n_o=0 for N_WD = max(ceil(t_ds/CLK_NS), ceil(t_wp/CLK_NS)-N_WZ, ceil(t_cyc/CLK_NS)-N_WZ-1) cycles, with mem_dq_o equal to the accepted write byte.
- R8: mem_we_n_o rises while the chip is still selected and mem_dq_oe_o is still 1. The drivers are released in the next cycle, which also carries rsp_done_o=1 and req_ready_o=1.
- R9: mem_we_n_o and mem_oe_n_o are never both 0, and mem_dq_oe_o is never 1 while mem_oe_n_o is 0.
- R10: mem_addr_o equals the accepted address for the whole access; req_addr_i changes after acceptance have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write byte |
| rsp_rdata_o | output | DATA_W | Last read byte |
| rsp_done_o | output | 1 | One-cycle completion strobe |
| mem_addr_o | output | ADDR_W | Memory address pins |
| mem_cs1_n_o | output | 1 | Chip select, active low |
| mem_cs2_o | output | 1 | Chip select, active high |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data bus drive value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | DATA_W | Data bus sampled value |

## Verification
The bench builds the controller with ADDR_W=6, CLK_NS=8 and the fast grade. The 64-byte space is small enough to write every address and read every one back against a memory model in the bench. At an 8 ns clock the derived windows are N_RD=4, N_RR=3, N_WZ=1 and N_WD=3. The bench recomputes these from the nanosecond figures and checks each window length and strobe position on every transaction. The bench drives mem_dq_i with the model's byte only while the output enable is low, so capturing in the wrong cycle shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_REC, ST_WR_Z, ST_WR_D, ST_WR_END
  } state_e;

  function automatic int ceil_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int N_RD  = 4,
  parameter int N_RR  = 3,
  parameter int N_WZ  = 1,
  parameter int N_WD  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             we_i,
  input  logic             last_i,
  output state_e           state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             done_o
);
  state_e state_q, state_d;
  logic   done_q;

  assign accept_o  = (state_q == ST_IDLE) && valid_i;
  assign capture_o = (state_q == ST_RD) && last_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (valid_i) begin
        load_o = 1'b1;
        if (we_i) begin
          state_d    = ST_WR_Z;
          load_val_o = CNT_W'(N_WZ - 1);
        end else begin
          state_d    = ST_RD;
          load_val_o = CNT_W'(N_RD - 1);
        end
      end
      ST_RD: if (last_i) begin
        state_d    = ST_RD_REC;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_RR - 1);
      end
      ST_RD_REC: if (last_i) state_d = ST_IDLE;
      ST_WR_Z: if (last_i) begin
        state_d    = ST_WR_D;
        load_o     = 1'b1;
        load_val_o = CNT_W'(N_WD - 1);
      end
      ST_WR_D:   if (last_i) state_d = ST_WR_END;
      ST_WR_END: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= capture_o || (state_q == ST_WR_END);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs1_n_o,
  output logic              cs2_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= dq_i;
    end
  end

  // write ends on the strobe: chip stays selected through ST_WR_END
  assign sel     = (state_i == ST_RD) || (state_i == ST_WR_Z) ||
                   (state_i == ST_WR_D) || (state_i == ST_WR_END);
  assign cs1_n_o = !sel;
  assign cs2_o   = sel;
  assign oe_n_o  = (state_i != ST_RD);
  assign we_n_o  = !((state_i == ST_WR_Z) || (state_i == ST_WR_D));
  assign dq_oe_o = (state_i == ST_WR_D) || (state_i == ST_WR_END);
  assign dq_o    = wdata_q;
  assign addr_o  = addr_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 8,
  parameter bit SLOW_GRADE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs1_n_o,
  output logic              mem_cs2_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int T_CYC = SLOW_GRADE ? 45 : 30;
  localparam int T_ACC = SLOW_GRADE ? 45 : 30;
  localparam int T_OE  = SLOW_GRADE ? 15 : 12;
  localparam int T_WP  = SLOW_GRADE ? 35 : 22;
  localparam int T_DS  = SLOW_GRADE ? 25 : 18;
  localparam int T_WZ  = SLOW_GRADE ? 15 : 8;
  localparam int T_CSZ = SLOW_GRADE ? 20 : 18;

  localparam int N_RD  = imax(ceil_cyc(T_ACC, CLK_NS), ceil_cyc(T_OE, CLK_NS));
  localparam int N_RR  = ceil_cyc(T_CSZ, CLK_NS);
  localparam int N_WZ  = ceil_cyc(T_WZ, CLK_NS);
  localparam int N_WD  = imax(ceil_cyc(T_DS, CLK_NS),
                         imax(ceil_cyc(T_WP, CLK_NS) - N_WZ,
                              ceil_cyc(T_CYC, CLK_NS) - N_WZ - 1));
  localparam int N_MAX = imax(imax(N_RD, N_RR), imax(N_WZ, N_WD));
  localparam int CNT_W = imax(1, $clog2(N_MAX + 1));

  state_e             state;
  logic               load, last, accept, capture;
  logic [CNT_W-1:0]   load_val;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_ctrl_fsm #(
    .CNT_W (CNT_W), .N_RD (N_RD), .N_RR (N_RR), .N_WZ (N_WZ), .N_WD (N_WD)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (req_valid_i),
    .we_i       (req_we_i),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .done_o     (rsp_done_o)
  );

  sram_ctrl_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .cs1_n_o   (mem_cs1_n_o),
    .cs2_o     (mem_cs2_o),
    .we_n_o    (mem_we_n_o),
    .oe_n_o    (mem_oe_n_o),
    .dq_o      (mem_dq_o),
    .dq_oe_o   (mem_dq_oe_o),
    .rdata_o   (rsp_rdata_o)
  );

  assign req_ready_o = (state == ST_IDLE);
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs1_n_o,
  input logic              mem_cs2_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_dq_oe_o
);
  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs1_n_o && !mem_cs2_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_read_pins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_cs1_n_o && mem_cs2_o));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  p_float_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> !mem_dq_oe_o);

  p_write_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && !mem_cs1_n_o && mem_cs2_o));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && mem_we_n_o) |=> !mem_dq_oe_o);

  p_no_contention_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o) && !(!mem_we_n_o && !mem_oe_n_o));

  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs1_n_o (mem_cs1_n_o),
  .mem_cs2_o   (mem_cs2_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int CLK = 8;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = mx(cdiv(30), cdiv(12));
  localparam int E_RR = cdiv(18);
  localparam int E_WZ = cdiv(8);
  localparam int E_WD = mx(cdiv(18), mx(cdiv(22) - E_WZ, cdiv(30) - E_WZ - 1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, dq_in = 8'h3C;
  logic ready, done, cs1_n, cs2, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_out;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mem [2**AW];
  int tests = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .SLOW_GRADE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rdata), .rsp_done_o(done),
    .mem_addr_o(maddr), .mem_cs1_n_o(cs1_n), .mem_cs2_o(cs2),
    .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n, wz, wd, done_at, rdy_at, rel_ok, addr_bad, dat_bad;
    bit prev_we_low;
    wz = 0; wd = 0; done_at = -1; rdy_at = -1; rel_ok = 0; addr_bad = 0; dat_bad = 0;
    prev_we_low = 0;
    while (!ready) @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; addr = ~a; wdata = ~d;
    chk(!ready, "R2", "ready after accept", ready, 0);
    for (n = 1; n < 40; n++) begin
      if (!cs1_n && maddr != a) addr_bad++;
      if (!we_n && !dq_oe) wz++;
      if (!we_n && dq_oe) begin
        wd++;
        if (dq_out != d) dat_bad++;
      end
      if (prev_we_low && we_n) begin
        rel_ok = (dq_oe && !cs1_n && cs2) ? 1 : 0;
        if (dq_oe) mem[maddr] = dq_out;
      end
      prev_we_low = !we_n;
      if (done) done_at = n;
      if (ready) begin rdy_at = n; break; end
      @(negedge clk);
    end
    chk(wz == E_WZ, "R6", "float wait cycles", wz, E_WZ);
    chk(wd == E_WD, "R7", "driven strobe cycles", wd, E_WD);
    chk(dat_bad == 0, "R7", "bus value mismatches", dat_bad, 0);
    chk(rel_ok == 1, "R8", "selected+driven at strobe rise", rel_ok, 1);
    chk(done_at == E_WZ + E_WD + 2, "R8", "write done cycle", done_at, E_WZ + E_WD + 2);
    chk(rdy_at == E_WZ + E_WD + 2 && !dq_oe, "R8", "ready/release cycle", rdy_at, E_WZ + E_WD + 2);
    chk(addr_bad == 0, "R10", "write address mismatches", addr_bad, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int n, oe_cnt, done_at, done_cnt, rdy_at, addr_bad;
    logic [DW-1:0] got;
    oe_cnt = 0; done_at = -1; done_cnt = 0; rdy_at = -1; addr_bad = 0; got = '0;
    while (!ready) @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0; addr = ~a;
    chk(!ready, "R2", "ready after accept", ready, 0);
    for (n = 1; n < 40; n++) begin
      if (!cs1_n && maddr != a) addr_bad++;
      if (!oe_n) begin
        oe_cnt++;
        dq_in = mem[maddr];
      end else dq_in = 8'h3C;
      if (done) begin done_at = n; done_cnt++; got = rdata; end
      if (ready) begin rdy_at = n; break; end
      @(negedge clk);
    end
    dq_in = 8'h3C;
    chk(oe_cnt == E_RD, "R3", "output enable cycles", oe_cnt, E_RD);
    chk(got == exp, "R4", "read data", got, exp);
    chk(done_at == E_RD + 1 && done_cnt == 1, "R4", "done cycle", done_at, E_RD + 1);
    chk(rdy_at == E_RD + E_RR + 1, "R5", "ready return cycle", rdy_at, E_RD + E_RR + 1);
    chk(addr_bad == 0, "R10", "read address mismatches", addr_bad, 0);
  endtask

  initial begin
    #(CLK * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = 8'h00;
    #(CLK * 3);
    @(negedge clk);
    chk(ready && cs1_n && !cs2 && we_n && oe_n && !dq_oe && !done, "R1", "reset pins",
        {ready, cs1_n, cs2, we_n, oe_n, dq_oe, done}, 7'b1101100);
    rst_n = 1'b1;
    // R1: idle with valid low and a moving address: no chip activity
    for (int k = 0; k < 6; k++) begin
      addr = AW'(k * 11); we = k[0];
      @(negedge clk);
      chk(cs1_n && !cs2 && we_n && oe_n && ready, "R1", "idle stays deselected",
          {cs1_n, cs2, we_n, oe_n}, 4'b1011);
    end
    // R9 edge patterns, then full sweep
    do_write(AW'(0), 8'h00);
    do_read(AW'(0), 8'h00);
    do_write(AW'(2**AW - 1), 8'hFF);
    do_read(AW'(2**AW - 1), 8'hFF);
    for (int a = 0; a < 2**AW; a++) do_write(AW'(a), DW'((a * 37 + 5) & 8'hFF));
    for (int a = 0; a < 2**AW; a++) do_read(AW'(a), DW'((a * 37 + 5) & 8'hFF));
    for (int a = 0; a < 2**AW; a += 7) begin
      do_write(AW'(a), DW'(~a));
      do_read(AW'(a), DW'(~a));
    end
    @(negedge clk);
    chk(ready && cs1_n && !done, "R1", "idle after traffic", {ready, cs1_n, done}, 3'b110);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule